// File: doc/BRIEF.md
# Indexed configuration register port

This block holds a 256-entry, byte-wide configuration register file that is reached through a two-address I/O window. The lower window address holds a pointer, and the upper address moves data to or from the entry the pointer selects. A read at either address returns the selected entry. Writes through the data address are dropped for a scattered set of protected entries. A few entries come out of reset with non-zero values. The whole array is also presented on a flat output bus so that neighbouring logic can decode it.

An enable bit taken from an upstream bridge configuration byte gates the window. While that bit is clear, the window stays silent: reads return all ones, and writes touch neither the pointer nor the array. The pointer keeps its value while the window is closed. No acknowledge is produced. All accesses are single bytes on a simple strobe bus.

Top module: `cfg_index_port`

## Requirements
- R1: After reset, entry 0xE0 is 0x3C, 0xE2 is 0x03, 0xE3 is 0xFC, 0xE6 is 0xDE, 0xE7 is 0xFE and 0xE8 is 0xBE. Every other entry is 0x00, and the pointer is 0x00.
- R2: A write at the pointer address (BASE_ADDR, default 0x3F0) loads `io_wdata` into the pointer and leaves every entry unchanged.
- R3: A write at the data address (BASE_ADDR+1) to an unprotected entry stores `io_wdata` into it at that clock edge. A read in the next cycle returns the new value.
- R4: A data write is dropped when the pointer is in 0x00–0xDF, 0xE9–0xED, 0xF9–0xFB or 0xFD–0xFF, or equals 0xE4, 0xE5, 0xF3, 0xF5 or 0xF7.
- R5: While `io_rd` is high and the window is open, `io_rdata` shows the entry selected by the pointer. This holds at either window address.
- R6: The window is open only while bit 1 of `bridge_cfg` is 1. While it is closed, reads return 0xFF and writes change neither the pointer nor any entry.
- R7: The pointer keeps its value across a close and reopen of the window.
- R8: Addresses other than BASE_ADDR and BASE_ADDR+1 read 0xFF and their writes have no effect.
- R9: A read in the same cycle as a write returns the contents from before that write. This applies both to a data write (old entry value) and to a pointer write (the entry at the old pointer).
- R10: `cfg_flat[8*i+7:8*i]` always equals entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_cfg | input | 8 | Bridge configuration byte; bit EN_BIT opens the window |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data (0xFF when not selected) |
| cfg_flat | output | 2048 | All 256 entries, entry i at bits 8*i+7:8*i |

## Verification
A read and a write can land in the same cycle. A data write can coincide with a read of the same entry, and a pointer write can coincide with a read through the data address. The bench drives both strobes together in one cycle. For the data case it expects the value from before the edge, and the following read must show the stored byte. For the pointer case it expects the entry at the old pointer, and the following read must follow the new pointer.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h03F0,
  parameter int          EN_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bridge_cfg,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic [2047:0]     cfg_flat
);
  localparam int NENT = 256;
  localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_ADDR) + ADDR_W'(1);

  logic [7:0] cfg_q [NENT];
  logic [7:0] idx_q;

  function automatic logic open_slot(input logic [7:0] i);
    logic r;
    unique case (i) inside
      [8'hE0:8'hE3], [8'hE6:8'hE8], [8'hEE:8'hF2],
      8'hF4, 8'hF6, 8'hF8, 8'hFC: r = 1'b1;
      default:                    r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] init_val(input int i);
    logic [7:0] v;
    case (i)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      8'hE7:   v = 8'hFE;
      8'hE8:   v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  wire win_on = bridge_cfg[EN_BIT];
  wire at_ptr = win_on && io_addr == PTR_A;
  wire at_dat = win_on && io_addr == DAT_A;
  wire wr_ptr = io_wr && at_ptr;
  wire wr_dat = io_wr && at_dat && open_slot(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 8'h00;
    else if (wr_ptr) idx_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) cfg_q[i] <= init_val(i);
    end else if (wr_dat) begin
      cfg_q[idx_q] <= io_wdata;
    end
  end

  assign io_rdata = (io_rd && (at_ptr || at_dat)) ? cfg_q[idx_q] : 8'hFF;

  for (genvar g = 0; g < NENT; g++) begin : g_flat
    assign cfg_flat[8*g +: 8] = cfg_q[g];
  end

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && win_on && io_addr == PTR_A) |=> idx_q == $past(io_wdata));

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && win_on && io_addr == DAT_A && open_slot(idx_q))
      |=> cfg_q[$past(idx_q)] == $past(io_wdata));

  p_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == DAT_A && !open_slot(idx_q))
      |=> cfg_q[$past(idx_q)] == $past(cfg_q[idx_q]));

  p_closed_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_on |=> $stable(idx_q));

  p_closed_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !win_on) |-> io_rdata == 8'hFF);
endmodule

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  logic clk = 0, rst_n = 0;
  logic [7:0] bridge_cfg = 8'h00;
  logic [15:0] io_addr = 16'h0;
  logic [7:0] io_wdata = 8'h0, io_rdata;
  logic io_wr = 0, io_rd = 0;
  logic [2047:0] cfg_flat;

  always #5 clk = ~clk;

  cfg_index_port u0 (.clk, .rst_n, .bridge_cfg, .io_addr, .io_wdata,
                     .io_wr, .io_rd, .io_rdata, .cfg_flat);

  localparam logic [15:0] PA = 16'h03F0, DA = 16'h03F1;

  int checks = 0, fails = 0;
  logic [7:0] model [256];
  logic [7:0] ptr = 8'h00;
  logic [7:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  function automatic logic guarded(input logic [7:0] i);
    return (i <= 8'hDF) || (i >= 8'hFD) || (i >= 8'hE9 && i <= 8'hED) ||
           (i >= 8'hF9 && i <= 8'hFB) || i == 8'hE4 || i == 8'hE5 ||
           i == 8'hF3 || i == 8'hF5 || i == 8'hF7;
  endfunction

  function automatic bit is_on();
    return bridge_cfg[1];
  endfunction

  // Monitor: pops one expected item per read strobe, mid-cycle
  always @(negedge clk) begin
    if (rst_n && io_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %h expected none", io_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (io_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, io_rdata, e);
        end
      end
    end
  end

  task automatic drive(input logic [15:0] a, input logic [7:0] d,
                       input bit w, input bit r, input string t);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = w; io_rd = r;
    if (r) begin
      exp_q.push_back((is_on() && (a == PA || a == DA)) ? model[ptr] : 8'hFF);
      tag_q.push_back(t);
    end
    if (w && is_on()) begin
      if (a == PA) ptr = d;
      else if (a == DA && !guarded(ptr)) model[ptr] = d;
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    io_wr = 0; io_rd = 0;
  endtask

  task automatic check_flat(input string t);
    idle();
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      checks++;
      if (cfg_flat[8*i +: 8] !== model[i]) begin
        fails++;
        $display("FAIL %s entry %0d: actual %h expected %h", t, i,
                 cfg_flat[8*i +: 8], model[i]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[8'hE0] = 8'h3C; model[8'hE2] = 8'h03; model[8'hE3] = 8'hFC;
    model[8'hE6] = 8'hDE; model[8'hE7] = 8'hFE; model[8'hE8] = 8'hBE;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 / R10: reset contents on the flat bus
    check_flat("R1 reset flat");
    // R6: closed window out of reset
    drive(DA, 8'h00, 0, 1, "R6 closed read");
    idle();

    bridge_cfg = 8'h02;
    // R1 pointer 0x00 after reset; R5 read at pointer address
    drive(PA, 8'h00, 0, 1, "R1 reset pointer entry");
    // R1 / R5 every entry via data address
    for (int i = 0; i < 256; i++) begin
      drive(PA, 8'(i), 1, 0, "");
      drive(DA, 8'h00, 0, 1, "R1 reset entry");
    end

    // R3 / R4: attempt writes at every index, read back at both addresses
    for (int i = 0; i < 256; i++) begin
      drive(PA, 8'(i), 1, 0, "");
      drive(DA, 8'(i) ^ 8'h5A, 1, 0, "");
      drive(DA, 8'h00, 0, 1, "R3/R4 data readback");
      drive(PA, 8'h00, 0, 1, "R5 pointer-address readback");
    end
    check_flat("R10 flat after writes");

    // R2: pointer writes leave entries untouched
    drive(PA, 8'hE7, 1, 0, "");
    drive(PA, 8'hF0, 1, 0, "");
    check_flat("R2 pointer write no entry change");

    // R9: data write and read same cycle, then new value
    drive(PA, 8'hF1, 1, 0, "");
    drive(DA, 8'h77, 1, 1, "R9 same-cycle data read old");
    drive(DA, 8'h00, 0, 1, "R3 next-cycle read new");
    // R9: pointer write and read same cycle
    drive(PA, 8'hE6, 1, 1, "R9 same-cycle pointer read old");
    drive(DA, 8'h00, 0, 1, "R9 read follows new pointer");
    // R4 guarded write next to a writable neighbour
    drive(PA, 8'hF3, 1, 0, "");
    drive(DA, 8'hAA, 1, 1, "R4 guarded before");
    drive(DA, 8'h00, 0, 1, "R4 guarded after");

    // R6 / R7: close using other bits set, bit 1 clear
    drive(PA, 8'hEE, 1, 0, "");
    drive(DA, 8'h11, 1, 0, "");
    idle();
    bridge_cfg = 8'hFD;
    drive(PA, 8'hE0, 1, 0, "");
    drive(DA, 8'h99, 1, 0, "");
    drive(DA, 8'h00, 0, 1, "R6 closed data read");
    drive(PA, 8'h00, 0, 1, "R6 closed pointer read");
    check_flat("R6 closed writes ignored");
    bridge_cfg = 8'h02;
    drive(DA, 8'h00, 0, 1, "R7 pointer kept after reopen");

    // R8: outside the window
    drive(16'h03F2, 8'h55, 1, 1, "R8 above window");
    drive(16'h03EF, 8'h55, 1, 1, "R8 below window");
    drive(16'h13F0, 8'h44, 1, 1, "R8 aliased high bits");
    drive(DA, 8'h00, 0, 1, "R8 pointer unchanged");
    check_flat("R8 outside writes ignored");

    idle();
    repeat (2) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard drain: actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule